// File: doc/BRIEF.md
# Serial Flash Command Controller

This block is the device-side front end of a serial flash. It runs on a system clock and samples the SPI pins chip select, serial clock and serial data in, using SPI mode 0 with most significant bit first. The block decodes each chip-select frame into an instruction. It keeps a write-enable latch and a busy flag. It also tracks whether the device is active, in standby or in deep power-down. Accepted program and erase work goes to a memory-array port as a stream of valid/ready beats. A countdown sized per operation keeps the device busy for the length of the internal cycle.

Page-program data is collected in a page-sized buffer while the frame arrives. Only when the frame is accepted does the buffer drain to the array. The drain sends one beat for each page offset that was written, in ascending offset order. On the array port the block is the source. `arr_valid` stays high until the sink raises `arr_ready`, and `arr_op`, `arr_addr` and `arr_data` do not change while `arr_valid` is high and `arr_ready` is low. A beat is transferred on a clock edge where both are high. A sink that holds `arr_ready` low makes the busy period longer. It never causes a beat to be lost. The SPI inputs must already be synchronous to `clk`, and the serial clock must stay at each level for at least two system clocks.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: An instruction (opcode 06h write-enable, 05h status read, 01h config write, 02h page program, D8h sector erase, C7h bulk erase, B9h sleep, ABh wake) takes effect only when chip select rises after a whole number of bytes. Frames that end mid-byte are dropped. So are frames shorter than the instruction needs: program needs opcode + address + at least one data byte, sector erase needs opcode + address, and config write needs 2 bytes.
- R2: Opcode 05h returns the status byte on `miso` in every following byte of the frame. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7:2 hold the config field. After reset the status byte is 00h. Write-enable (06h) sets bit 1.
- R3: Program, sector erase, bulk erase and config write are ignored while the write-enable latch is clear.
- R4: Once a program, erase or config write is accepted, busy reads 1 for at least the parameter cycle count of that operation. It then reads 0, and the write-enable latch clears at that same moment.
- R5: While busy is 1, every instruction other than the status read is ignored.
- R6: `pwr_mode` is 0 (active) while chip select is low. After chip select rises it stays 0 until any internal cycle ends, and then becomes 1 (standby).
- R7: Opcode B9h puts the device in deep power-down (`pwr_mode` 2). Only ABh brings it out, to standby. While in deep power-down every other instruction is ignored, including the status read (`miso` stays 0), and the latch keeps its value.
- R8: A page program sends one beat with `arr_op` 0 for each written page offset, in ascending offset order, with `arr_addr` = page base + offset. Data bytes that run past the page end wrap to the page start, and the later byte overwrites the earlier one.
- R9: A sector erase sends one beat with `arr_op` 1 and the received address. A bulk erase sends one beat with `arr_op` 2 and address 0.
- R10: `arr_valid` holds with stable fields until `arr_ready` is high, and busy stays 1 until every beat has been taken.
- R11: Config write (01h) copies bits 7:2 of its data byte into status bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device |
| arr_valid | output | 1 | Array beat valid |
| arr_ready | input | 1 | Array sink ready |
| arr_op | output | 2 | 0 program, 1 sector erase, 2 bulk erase |
| arr_addr | output | ADDR_W | Byte address of the beat |
| arr_data | output | 8 | Program data (0 for erases) |
| pwr_mode | output | 2 | 0 active, 1 standby, 2 deep power-down |

## Verification
The bench builds the block with a 16-byte page and a 24-bit address. This lets one 20-byte program frame wrap across the page end and overwrite four earlier offsets. Busy durations of 120 to 250 clocks are long enough for a status read to land inside each cycle and for the active-to-standby change to be timed against the program count. The same durations keep a sink stall, held past the erase count, short enough to show that busy is extended by the stall.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OPC_WEN    = 8'h06;
  localparam logic [7:0] OPC_STAT   = 8'h05;
  localparam logic [7:0] OPC_SETCFG = 8'h01;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_SECT   = 8'hD8;
  localparam logic [7:0] OPC_BULK   = 8'hC7;
  localparam logic [7:0] OPC_SLEEP  = 8'hB9;
  localparam logic [7:0] OPC_WAKE   = 8'hAB;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'd0,
    PWR_STANDBY = 2'd1,
    PWR_DEEP    = 2'd2
  } pwr_e;

  typedef enum logic [1:0] {
    AOP_PROG = 2'd0,
    AOP_SECT = 2'd1,
    AOP_BULK = 2'd2
  } aop_e;
endpackage

// File: rtl/sfc_spi_shifter.sv
module sfc_spi_shifter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  input  logic [7:0]       status_byte,
  input  logic             rd_on,
  output logic             miso,
  output logic             byte_stb,
  output logic [7:0]       byte_data,
  output logic [CNT_W-1:0] byte_num,
  output logic             frame_start,
  output logic             frame_end,
  output logic             whole,
  output logic             cs_q
);
  logic             sclk_q;
  logic [6:0]       sh_in;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] nbytes;
  logic [7:0]       out_sh;
  logic             rise, fall;

  assign rise        = ~cs_n & sclk & ~sclk_q;
  assign fall        = ~cs_n & ~sclk & sclk_q;
  assign byte_stb    = rise && (bit_cnt == 3'd7);
  assign byte_data   = {sh_in, mosi};
  assign byte_num    = nbytes;
  assign frame_start = ~cs_n & cs_q;
  assign frame_end   = cs_n & ~cs_q;
  assign whole       = (bit_cnt == 3'd0);
  assign miso        = out_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      sh_in   <= '0;
      bit_cnt <= '0;
      nbytes  <= '0;
      out_sh  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (frame_start) begin
        bit_cnt <= '0;
        nbytes  <= '0;
        out_sh  <= '0;
      end else begin
        if (rise) begin
          sh_in   <= {sh_in[5:0], mosi};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7 && nbytes != {CNT_W{1'b1}}) nbytes <= nbytes + 1'b1;
        end
        if (fall) begin
          if (bit_cnt == 3'd0 && rd_on) out_sh <= status_byte;
          else                          out_sh <= {out_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R1: the byte counter moves only on a completed byte
  a_r1_count_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !byte_stb) |=> $stable(nbytes));
endmodule

// File: rtl/sfc_busy_timer.sv
module sfc_busy_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         run
);
  logic [W-1:0] cnt;

  assign run = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt - 1'b1;
  end

  // R4: a running count steps down by exactly one each cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sfc_array_port.sv
module sfc_array_port import sfc_pkg::*; #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic [7:0]              wr_data,
  input  logic                    prog_go,
  input  logic [ADDR_W-OFF_W-1:0] page_hi,
  input  logic                    erase_go,
  input  logic [1:0]              erase_op,
  input  logic [ADDR_W-1:0]       erase_addr,
  input  logic                    arr_ready,
  output logic                    arr_valid,
  output logic [1:0]              arr_op,
  output logic [ADDR_W-1:0]       arr_addr,
  output logic [7:0]              arr_data,
  output logic                    busy
);
  logic [7:0]              pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   mask;
  logic                    scan, er_pend;
  logic [OFF_W-1:0]        ptr;
  logic [ADDR_W-OFF_W-1:0] hi_q;
  logic [1:0]              er_op;
  logic [ADDR_W-1:0]       er_addr;
  logic                    prog_beat;

  assign prog_beat = scan & mask[ptr];
  assign arr_valid = er_pend | prog_beat;
  assign arr_op    = er_pend ? er_op : AOP_PROG;
  assign arr_addr  = er_pend ? er_addr : {hi_q, ptr};
  assign arr_data  = er_pend ? 8'h00 : pbuf[ptr];
  assign busy      = er_pend | scan;

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_off] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      scan    <= 1'b0;
      ptr     <= '0;
      hi_q    <= '0;
      er_pend <= 1'b0;
      er_op   <= AOP_SECT;
      er_addr <= '0;
    end else begin
      if (clr)        mask <= '0;
      else if (wr_en) mask[wr_off] <= 1'b1;
      if (prog_go) begin
        scan <= 1'b1;
        ptr  <= '0;
        hi_q <= page_hi;
      end else if (scan && !(prog_beat && !arr_ready)) begin
        ptr <= ptr + 1'b1;
        if (ptr == OFF_W'(PAGE_BYTES - 1)) scan <= 1'b0;
      end
      if (erase_go) begin
        er_pend <= 1'b1;
        er_op   <= erase_op;
        er_addr <= erase_addr;
      end else if (er_pend && arr_ready) begin
        er_pend <= 1'b0;
      end
    end
  end

  // R10: a stalled beat keeps its valid and all of its fields
  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !arr_ready) |=> (arr_valid && $stable(arr_addr) && $stable(arr_data) && $stable(arr_op)));
  // R8: program beats and erase beats never overlap
  a_r8_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(er_pend && scan));
endmodule

// File: rtl/sflash_cmd_ctrl.sv
module sflash_cmd_ctrl import sfc_pkg::*; #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  parameter int T_PROG     = 4000,
  parameter int T_SECT     = 60000,
  parameter int T_BULK     = 250000,
  parameter int T_CFG      = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              arr_valid,
  input  logic              arr_ready,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic [1:0]        pwr_mode
);
  localparam int AB    = ADDR_W / 8;
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(AB + 3) + 1;
  localparam int T_M1  = (T_PROG > T_SECT) ? T_PROG : T_SECT;
  localparam int T_M2  = (T_BULK > T_CFG) ? T_BULK : T_CFG;
  localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int TMR_W = $clog2(T_MAX + 1);

  logic             byte_stb, frame_start, frame_end, whole, cs_q;
  logic [7:0]       byte_data, op_q;
  logic [CNT_W-1:0] byte_num;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [5:0]       cfg_q, cfg_in;
  logic [OFF_W-1:0] wptr;
  logic             wel, deep, cyc_on, rd_on, tmr_run, port_busy;
  logic             acc, live, wen_go, sleep_go, wake_go;
  logic             cfg_go, prog_go, sect_go, bulk_go, start;
  logic             buf_we;
  logic [TMR_W-1:0] tmr_val;
  logic [7:0]       status_byte;

  assign status_byte = {cfg_q, wel, cyc_on};
  assign rd_on       = (op_q == OPC_STAT) && (byte_num != '0) && !deep;
  assign addr_nx     = {addr_q[ADDR_W-9:0], byte_data};
  assign buf_we      = byte_stb && (byte_num >= CNT_W'(AB + 1)) && (op_q == OPC_PROG) && !cyc_on && !deep;

  sfc_spi_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .status_byte(status_byte), .rd_on(rd_on), .miso(spi_miso),
    .byte_stb(byte_stb), .byte_data(byte_data), .byte_num(byte_num),
    .frame_start(frame_start), .frame_end(frame_end), .whole(whole), .cs_q(cs_q)
  );

  always_comb begin
    acc      = frame_end && whole && (byte_num != '0);
    wake_go  = acc && deep && (op_q == OPC_WAKE);
    live     = acc && !deep && !cyc_on;
    wen_go   = live && (op_q == OPC_WEN);
    sleep_go = live && (op_q == OPC_SLEEP);
    cfg_go   = live && wel && (op_q == OPC_SETCFG) && (byte_num >= CNT_W'(2));
    prog_go  = live && wel && (op_q == OPC_PROG) && (byte_num >= CNT_W'(AB + 2));
    sect_go  = live && wel && (op_q == OPC_SECT) && (byte_num >= CNT_W'(AB + 1));
    bulk_go  = live && wel && (op_q == OPC_BULK);
    start    = cfg_go | prog_go | sect_go | bulk_go;
    if (prog_go)      tmr_val = TMR_W'(T_PROG);
    else if (sect_go) tmr_val = TMR_W'(T_SECT);
    else if (bulk_go) tmr_val = TMR_W'(T_BULK);
    else              tmr_val = TMR_W'(T_CFG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      cfg_in <= '0;
      wptr   <= '0;
    end else if (byte_stb) begin
      if (byte_num == '0) op_q <= byte_data;
      else if (byte_num <= CNT_W'(AB)) begin
        addr_q <= addr_nx;
        if (byte_num == CNT_W'(1)) cfg_in <= byte_data[7:2];
        if (byte_num == CNT_W'(AB)) wptr <= addr_nx[OFF_W-1:0];
      end else if (buf_we) begin
        wptr <= wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      deep   <= 1'b0;
      cyc_on <= 1'b0;
      cfg_q  <= '0;
    end else begin
      if (wen_go) wel <= 1'b1;
      if (sleep_go) deep <= 1'b1;
      else if (wake_go) deep <= 1'b0;
      if (cfg_go) cfg_q <= cfg_in;
      if (start) cyc_on <= 1'b1;
      else if (cyc_on && !tmr_run && !port_busy) begin
        cyc_on <= 1'b0;
        wel    <= 1'b0;
      end
    end
  end

  sfc_busy_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(tmr_val), .run(tmr_run)
  );

  sfc_array_port #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_port (
    .clk(clk), .rst_n(rst_n), .clr(frame_start && !cyc_on),
    .wr_en(buf_we), .wr_off(wptr), .wr_data(byte_data),
    .prog_go(prog_go), .page_hi(addr_q[ADDR_W-1:OFF_W]),
    .erase_go(sect_go | bulk_go), .erase_op(sect_go ? AOP_SECT : AOP_BULK),
    .erase_addr(sect_go ? addr_q : '0), .arr_ready(arr_ready),
    .arr_valid(arr_valid), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_data(arr_data), .busy(port_busy)
  );

  always_comb begin
    if (deep)                 pwr_mode = PWR_DEEP;
    else if (!cs_q || cyc_on) pwr_mode = PWR_ACTIVE;
    else                      pwr_mode = PWR_STANDBY;
  end

  // R3: an internal cycle only begins with the latch set
  a_r3_latch_before_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cyc_on) |-> $past(wel));
  // R4: the latch is clear when the cycle ends
  a_r4_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cyc_on) |-> !wel);
  // R5: no entry into deep power-down while busy
  a_r5_busy_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_on && !deep) |=> !deep);
  // R7: deep power-down never has array traffic or a running cycle
  a_r7_deep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    deep |-> (!cyc_on && !arr_valid && !tmr_run));
endmodule

// File: tb/sflash_cmd_ctrl_tb.sv
module sflash_cmd_ctrl_tb_top;
  localparam int AW = 24, PG = 16;
  localparam int TP = 150, TS = 200, TB = 250, TC = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, arr_ready = 1'b1;
  logic miso, arr_valid;
  logic [1:0] arr_op, pwr_mode;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;
  int checks = 0, errors = 0, nbeat = 0;
  logic [1:0]    lg_op   [64];
  logic [AW-1:0] lg_addr [64];
  logic [7:0]    lg_data [64];
  bit done = 1'b0;

  always #2 clk = ~clk;

  sflash_cmd_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PG), .T_PROG(TP), .T_SECT(TS),
    .T_BULK(TB), .T_CFG(TC)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_op(arr_op),
    .arr_addr(arr_addr), .arr_data(arr_data), .pwr_mode(pwr_mode));

  always begin
    @(negedge clk); #1;
    if (arr_valid && arr_ready && nbeat < 64) begin
      lg_op[nbeat] = arr_op; lg_addr[nbeat] = arr_addr; lg_data[nbeat] = arr_data;
      nbeat++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbegin(); cs_n = 1'b0; clks(2); endtask
  task automatic send(); clks(2); cs_n = 1'b1; clks(2); endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i]; clks(2); rx[i] = miso; sclk = 1'b1; clks(2); sclk = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1; clks(2); sclk = 1'b1; clks(2); sclk = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    sbegin(); xb(op); send();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input int nb);
    sbegin(); xb(op);
    for (int i = 0; i < nb; i++) xb(a[23-8*i -: 8]);
    send();
  endtask

  task automatic prog(input logic [23:0] a, input int n, input logic [7:0] first);
    sbegin(); xb(8'h02); xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
    for (int i = 0; i < n; i++) xb(first + 8'(i));
    send();
  endtask

  task automatic rdsr(output logic [7:0] st);
    sbegin(); xb(8'h05); xfer(8'h00, st); send();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int i = 0; i < 60; i++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] st;
    chk(pwr_mode == 2'd1, "R6 standby after reset", 32'(pwr_mode), 1);
    chk(!arr_valid, "R10 idle port", 32'(arr_valid), 0);
    rdsr(st);
    chk(st == 8'h00, "R2 reset status", st, 8'h00);
  endtask

  task automatic t_no_latch();
    logic [7:0] st;
    int b0 = nbeat;
    cmd_addr(8'hD8, 24'h000200, 3); prog(24'h000010, 2, 8'h55); cmd(8'hC7);
    sbegin(); xb(8'h01); xb(8'hFC); send();
    clks(20); rdsr(st);
    chk(nbeat == b0, "R3 no beats without latch", nbeat, b0);
    chk(st == 8'h00, "R3 status unchanged", st, 8'h00);
  endtask

  task automatic t_frames();
    logic [7:0] st;
    sbegin(); xb(8'h06); bits(3); send(); rdsr(st);
    chk(st == 8'h00, "R1 frame ending mid-byte dropped", st, 8'h00);
    sbegin(); bits(7); send(); rdsr(st);
    chk(st == 8'h00, "R1 seven-bit frame dropped", st, 8'h00);
    cmd(8'h06); rdsr(st);
    chk(st == 8'h02, "R2 write-enable sets bit 1", st, 8'h02);
    cmd_addr(8'hD8, 24'h012300, 2); clks(20);
    chk(nbeat == 0, "R1 short erase frame dropped", nbeat, 0);
    rdsr(st);
    chk(st == 8'h02, "R1 latch kept after short frame", st, 8'h02);
  endtask

  task automatic t_prog_basic();
    logic [7:0] st;
    int b0 = nbeat, n = 0;
    sbegin();
    chk(pwr_mode == 2'd0, "R6 active while selected", 32'(pwr_mode), 0);
    xb(8'h02); xb(8'h00); xb(8'h01); xb(8'h23); xb(8'h11); xb(8'h22); xb(8'h33);
    send();
    while (pwr_mode == 2'd0 && n < 1000) begin clks(1); n++; end
    chk(n >= TP - 4 && n <= TP + 8, "R6 active until cycle ends", n, TP);
    chk(pwr_mode == 2'd1, "R6 standby after cycle", 32'(pwr_mode), 1);
    rdsr(st);
    chk(st == 8'h00, "R4 busy and latch clear after cycle", st, 8'h00);
    chk(nbeat == b0 + 3, "R8 three beats", nbeat, b0 + 3);
    for (int i = 0; i < 3; i++) begin
      chk(lg_addr[b0+i] == 24'h000123 + 24'(i) && lg_op[b0+i] == 2'd0,
          "R8 program beat address", lg_addr[b0+i], 24'h000123 + 24'(i));
      chk(lg_data[b0+i] == 8'h11 * 8'(i + 1), "R8 program beat data", lg_data[b0+i], 8'h11 * 8'(i + 1));
    end
  endtask

  task automatic t_busy_read();
    logic [7:0] st;
    cmd(8'h06); prog(24'h000040, 1, 8'h77); rdsr(st);
    chk(st == 8'h03, "R4 busy reads 1 during cycle", st, 8'h03);
    wait_idle(); rdsr(st);
    chk(st == 8'h00, "R4 latch cleared on completion", st, 8'h00);
  endtask

  task automatic t_wrap();
    int b0 = nbeat;
    bit ok = 1'b1;
    cmd(8'h06); prog(24'h000A5C, 20, 8'h30); wait_idle();
    chk(nbeat == b0 + PG, "R8 wrapped page beat count", nbeat, b0 + PG);
    for (int o = 0; o < PG; o++)
      if (lg_addr[b0+o] != 24'h000A50 + 24'(o) || lg_data[b0+o] != 8'h34 + 8'(o)) ok = 1'b0;
    chk(ok, "R8 wrap stays in page, later byte wins", lg_data[b0], 8'h34);
  endtask

  task automatic t_erase();
    int b0 = nbeat;
    cmd(8'h06); cmd_addr(8'hD8, 24'h012345, 3); wait_idle();
    chk(nbeat == b0 + 1 && lg_op[b0] == 2'd1 && lg_addr[b0] == 24'h012345,
        "R9 sector erase beat", lg_addr[b0], 24'h012345);
    cmd(8'h06); cmd(8'hC7); wait_idle();
    chk(nbeat == b0 + 2 && lg_op[b0+1] == 2'd2 && lg_addr[b0+1] == 24'h0,
        "R9 bulk erase beat", lg_op[b0+1], 2);
  endtask

  task automatic t_backpressure();
    logic [7:0] st;
    int b0 = nbeat;
    arr_ready = 1'b0;
    cmd(8'h06); cmd_addr(8'hD8, 24'h00ABCD, 3); clks(TS + 50);
    chk(arr_valid && arr_addr == 24'h00ABCD && arr_op == 2'd1, "R10 beat held while stalled", arr_addr, 24'h00ABCD);
    chk(pwr_mode == 2'd0, "R10 still active while stalled", 32'(pwr_mode), 0);
    rdsr(st);
    chk(st[0] == 1'b1, "R10 busy extends past timer", st, 8'h03);
    chk(nbeat == b0, "R10 nothing taken while stalled", nbeat, b0);
    arr_ready = 1'b1; wait_idle();
    chk(nbeat == b0 + 1 && lg_addr[b0] == 24'h00ABCD, "R10 beat taken once", nbeat, b0 + 1);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] st;
    int b0 = nbeat;
    cmd(8'h06); cmd_addr(8'hD8, 24'h000100, 3);
    cmd(8'hB9);
    chk(pwr_mode == 2'd0, "R5 sleep ignored while busy", 32'(pwr_mode), 0);
    cmd(8'hC7); wait_idle(); rdsr(st);
    chk(nbeat == b0 + 1, "R5 bulk erase ignored while busy", nbeat, b0 + 1);
    chk(st == 8'h00 && pwr_mode == 2'd1, "R5 idle after cycle", st, 8'h00);
  endtask

  task automatic t_deep();
    logic [7:0] st;
    int b0 = nbeat;
    cmd(8'h06); cmd(8'hB9);
    chk(pwr_mode == 2'd2, "R7 deep power-down entered", 32'(pwr_mode), 2);
    rdsr(st);
    chk(st == 8'h00, "R7 status read ignored in deep", st, 8'h00);
    cmd(8'hC7); cmd_addr(8'hD8, 24'h000300, 3); prog(24'h000000, 2, 8'h01); clks(TB + 20);
    chk(nbeat == b0, "R7 writes ignored in deep", nbeat, b0);
    sbegin();
    chk(pwr_mode == 2'd2, "R7 selection keeps deep", 32'(pwr_mode), 2);
    send();
    cmd(8'hAB);
    chk(pwr_mode == 2'd1, "R7 wake gives standby", 32'(pwr_mode), 1);
    rdsr(st);
    chk(st == 8'h02, "R7 latch kept, no cycle ran", st, 8'h02);
  endtask

  task automatic t_cfg();
    logic [7:0] st;
    sbegin(); xb(8'h01); xb(8'hA9); send(); rdsr(st);
    chk(st == 8'hAB, "R11 config applied, busy and latch set", st, 8'hAB);
    wait_idle(); rdsr(st);
    chk(st == 8'hA8, "R11 config bits 7:2 kept", st, 8'hA8);
  endtask

  initial begin
    clks(4); rst_n = 1'b1; clks(4);
    t_reset(); t_no_latch(); t_frames(); t_prog_basic(); t_busy_read();
    t_wrap(); t_erase(); t_backpressure(); t_busy_ignore(); t_deep(); t_cfg();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule